// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit sits on the bus side of a processor core and keeps a short run of instruction bytes ready for the execution side. From a 16-bit code segment and a 16-bit fetch offset it forms a 20-bit physical address. It reads one 16-bit word per fixed four-cycle bus transaction and loads the bytes into a six-entry byte queue. Fetching goes on by itself whenever the queue has room for a whole word, so bytes build up while the consumer is busy.

The consumer takes one byte at a time through a valid/data/pop interface. A branch request empties the queue at once and drops any bus transaction in progress. Fetching then restarts from the new segment and offset. An odd target offset is handled by fetching the word that contains it and keeping only its upper byte. Every fetch after that is word-aligned.

Top module: `ifq_prefetch`

## Requirements
- R1: The bus address is ({segment, 4'b0000} + {4'b0000, offset}) truncated to 20 bits, where offset is the current fetch offset with bit 0 cleared, so every request address is even.
- R2: Each word fetch holds mem_req high for exactly 4 consecutive clock cycles with mem_addr constant, and mem_rdata is captured in the fourth of those cycles.
- R3: The queue never holds more than 6 bytes; fill_level reports the byte count.
- R4: A new fetch starts only when fill_level is 4 or less; with no pops the queue stops filling and mem_req stays low.
- R5: Byte mem_rdata[7:0] (the lower address) enters the queue before mem_rdata[15:8], so bytes reach the consumer in rising address order.
- R6: A cycle with br_valid high empties the queue (fill_level 0 on the next cycle), discards any fetch in flight, and later bytes come from br_seg:br_off.
- R7: For an odd target offset, the first fetched word adds only its upper byte to the queue.
- R8: After each word the fetch offset grows by 2, wrapping modulo 65536; the segment never changes except on a branch.
- R9: A pop while the queue is empty has no effect; a pop in the cycle of a word push changes fill_level by +1.
- R10: During and right after reset the queue is empty, byte_valid is low and mem_req is low.
- R11: Left unpopped after a branch, the queue settles at 6 bytes for an even target and 5 for an odd one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch request: flush and redirect |
| br_seg | input | 16 | Branch target code segment |
| br_off | input | 16 | Branch target offset |
| mem_req | output | 1 | Bus transaction active |
| mem_addr | output | 20 | Physical word address |
| mem_rdata | input | 16 | Word read data, valid in the last bus cycle |
| pop | input | 1 | Consumer takes the head byte |
| byte_valid | output | 1 | Queue not empty |
| byte_data | output | 8 | Head byte of the queue |
| fill_level | output | 3 | Number of bytes held |

## Verification
The assertions assume that memory answers with fixed timing: mem_rdata must be valid in the fourth request cycle, and no wait or ready handshake exists. They also assume that br_valid and pop are free-running single-cycle strobes that may arrive at any point of a bus transaction. The bench drives mem_rdata combinationally from mem_addr through a byte-per-address model, so data is always valid when it is sampled. It raises every strobe for exactly one cycle between falling edges, including branches in the middle of a transaction and pops on an empty queue.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    localparam int SEG_W  = 16;
    localparam int PHYS_W = 20;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [PHYS_W-1:0] paddr_t;

    // Paragraph-aligned segment base plus offset, 20-bit wrap.
    function automatic paddr_t phys_of(input seg_t seg, input seg_t off);
        return {seg, 4'h0} + {4'h0, off};
    endfunction
endpackage

// File: rtl/ifq_addr_gen.sv
module ifq_addr_gen
    import ifq_pkg::*;
#(
    parameter logic [15:0] RESET_SEG = 16'h0000,
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  seg_t   load_seg,
    input  seg_t   load_off,
    input  logic   advance,
    output paddr_t word_addr,
    output logic   skip_low
);
    typedef struct packed {
        seg_t seg;
        seg_t off;
        logic skip;
    } ag_t;

    ag_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.seg  = load_seg;
            s_d.off  = {load_off[15:1], 1'b0};
            s_d.skip = load_off[0];
        end else if (advance) begin
            s_d.off  = s_q.off + 16'd2;   // wraps inside the segment
            s_d.skip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.seg  <= RESET_SEG;
            s_q.off  <= {RESET_OFF[15:1], 1'b0};
            s_q.skip <= RESET_OFF[0];
        end else begin
            s_q <= s_d;
        end
    end

    assign word_addr = phys_of(s_q.seg, s_q.off);
    assign skip_low  = s_q.skip;

    AST_SEG_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && advance) |=> (s_q.seg == $past(s_q.seg))) else $error("seg moved"); // R8
endmodule

// File: rtl/ifq_bus_seq.sv
module ifq_bus_seq #(
    parameter int BUS_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic room_ok,
    output logic req,
    output logic done
);
    localparam int CW = (BUS_CYCLES > 2) ? $clog2(BUS_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BUS_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } bs_t;

    bs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (room_ok) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req  = s_q.busy;
    assign done = s_q.busy && (s_q.cnt == LAST) && !flush;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done && !flush) |=> req) else $error("request dropped early"); // R2
endmodule

// File: rtl/ifq_byte_queue.sv
module ifq_byte_queue #(
    parameter int DEPTH = 6,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_lo,
    input  logic          push_hi,
    input  logic [15:0]   wdata,
    input  logic          pop,
    output logic          valid,
    output logic [7:0]    rdata,
    output logic [LW-1:0] level
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [LW-1:0]         cnt;
    } bq_t;

    bq_t s_d, s_q;

    function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] p, input logic [1:0] k);
        logic [PW:0] s;
        s = {1'b0, p} + (PW+1)'(k);
        if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
        return s[PW-1:0];
    endfunction

    logic       do_pop;
    logic [1:0] n_push;
    logic [7:0] first_b;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        n_push  = {1'b0, push_lo} + {1'b0, push_hi};
        first_b = push_lo ? wdata[7:0] : wdata[15:8];
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (n_push != 2'd0) s_d.mem[s_q.wr] = first_b;
            if (n_push == 2'd2) s_d.mem[ring_add(s_q.wr, 2'd1)] = wdata[15:8];
            s_d.wr  = ring_add(s_q.wr, n_push);
            if (do_pop) s_d.rd = ring_add(s_q.rd, 2'd1);
            s_d.cnt = s_q.cnt + LW'(n_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = (s_q.cnt != '0);
    assign rdata = s_q.mem[s_q.rd];
    assign level = s_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LW'(DEPTH)) else $error("queue overflow"); // R3
    AST_POP_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0 && pop && !push_lo && !push_hi && !flush) |=> (s_q.cnt == '0)) else $error("pop on empty"); // R9
endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch
    import ifq_pkg::*;
#(
    parameter int          DEPTH      = 6,
    parameter int          BUS_CYCLES = 4,
    parameter logic [15:0] RESET_SEG  = 16'h0000,
    parameter logic [15:0] RESET_OFF  = 16'h0000,
    parameter int          LW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic [15:0]   br_seg,
    input  logic [15:0]   br_off,
    output logic          mem_req,
    output logic [19:0]   mem_addr,
    input  logic [15:0]   mem_rdata,
    input  logic          pop,
    output logic          byte_valid,
    output logic [7:0]    byte_data,
    output logic [LW-1:0] fill_level
);
    logic fetch_done;
    logic skip_low;
    logic room_ok;

    assign room_ok = (fill_level <= LW'(DEPTH - 2));

    ifq_addr_gen #(.RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(br_valid), .load_seg(br_seg), .load_off(br_off),
        .advance(fetch_done),
        .word_addr(mem_addr), .skip_low(skip_low)
    );

    ifq_bus_seq #(.BUS_CYCLES(BUS_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .flush(br_valid), .room_ok(room_ok),
        .req(mem_req), .done(fetch_done)
    );

    ifq_byte_queue #(.DEPTH(DEPTH), .LW(LW)) u_q (
        .clk(clk), .rst_n(rst_n),
        .flush(br_valid),
        .push_lo(fetch_done && !skip_low), .push_hi(fetch_done),
        .wdata(mem_rdata), .pop(pop),
        .valid(byte_valid), .rdata(byte_data), .level(fill_level)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (fill_level == '0 && !mem_req)) else $error("flush left data"); // R6
    AST_ROOM_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (fill_level <= LW'(DEPTH - 2))) else $error("fetch without room"); // R4
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !fetch_done && !br_valid) |=> (mem_req && $stable(mem_addr))) else $error("addr moved"); // R2
endmodule

// File: tb/ifq_prefetch_test.sv
module ifq_prefetch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [15:0] br_seg = '0;
    logic [15:0] br_off = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        pop = 1'b0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic [2:0]  fill_level;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] bmod(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
    endfunction

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    assign mem_rdata = {bmod(mem_addr + 20'd1), bmod(mem_addr)};

    ifq_prefetch uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_seg(br_seg), .br_off(br_off),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pop(pop),
        .byte_valid(byte_valid), .byte_data(byte_data), .fill_level(fill_level)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic branch(input logic [15:0] s, input logic [15:0] o);
        br_valid = 1'b1; br_seg = s; br_off = o;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic pop_check(input logic [7:0] exp, input string tag);
        for (int g = 0; g < 40 && !byte_valid; g++) @(negedge clk);
        chk(byte_valid && byte_data == exp, tag, {23'd0, byte_valid, byte_data}, {24'd1, exp});
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    // {segment, offset, settled level}
    localparam logic [35:0] VEC [5] = '{
        {16'h1234, 16'h0010, 4'd6},
        {16'hF000, 16'hFFFF, 4'd5},
        {16'hFFFF, 16'h0020, 4'd6},
        {16'h0800, 16'h0003, 4'd5},
        {16'hABCD, 16'hFFFE, 4'd6}
    };

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fill_level == 0 && !byte_valid && !mem_req, "R10 reset state",
            {28'd0, fill_level, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fill_level == 0 && !byte_valid, "R10 after reset", {29'd0, fill_level}, 32'd0);

        // Table-driven: fill, settle, drain in address order
        for (int v = 0; v < 5; v++) begin
            logic [15:0] s, o;
            logic [3:0]  lvl;
            {s, o, lvl} = VEC[v];
            branch(s, o);
            repeat (20) @(negedge clk);
            chk(fill_level == lvl[2:0], "R11 settled level", {29'd0, fill_level}, {28'd0, lvl});
            chk(!mem_req, "R4 no fetch without room", {31'd0, mem_req}, 32'd0);
            for (int i = 0; i < int'(lvl) + 2; i++)
                pop_check(bmod(pa(s, o + 16'(i))), "R5 R7 R8 byte order");
        end

        // R1 R2: request timing and address
        branch(16'h2000, 16'h0104);
        chk(!mem_req, "R6 request dropped by branch", {31'd0, mem_req}, 32'd0);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk(mem_req == (k <= 4), "R2 request length", {31'd0, mem_req}, {31'd0, k <= 4});
            if (k == 1) chk(mem_addr == 20'h20104, "R1 address", {12'd0, mem_addr}, 32'h20104);
        end
        chk(fill_level == 2 && byte_data == bmod(20'h20104), "R5 low byte first",
            {21'd0, fill_level, byte_data}, {21'd0, 3'd2, bmod(20'h20104)});

        // R9: pop in the push cycle
        branch(16'h3000, 16'h0000);
        repeat (9) @(negedge clk);
        chk(fill_level == 2, "R9 before push", {29'd0, fill_level}, 32'd2);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk(fill_level == 3, "R9 push with pop", {29'd0, fill_level}, 32'd3);
        chk(byte_data == bmod(20'h30001), "R9 head after pop", {24'd0, byte_data}, {24'd0, bmod(20'h30001)});

        // R9: pop while empty
        branch(16'h4000, 16'h0010);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk(fill_level == 0, "R9 empty pop", {29'd0, fill_level}, 32'd0);
        repeat (20) @(negedge clk);
        chk(fill_level == 6 && byte_data == bmod(20'h40010), "R9 empty pop no effect",
            {21'd0, fill_level, byte_data}, {21'd0, 3'd6, bmod(20'h40010)});

        // R6 R7: branch during a fetch
        branch(16'h5000, 16'h0000);
        repeat (3) @(negedge clk);
        branch(16'h6000, 16'h0007);
        chk(fill_level == 0, "R6 flush mid-fetch", {29'd0, fill_level}, 32'd0);
        repeat (20) @(negedge clk);
        chk(fill_level == 5, "R7 odd target level", {29'd0, fill_level}, 32'd5);
        chk(byte_data == bmod(20'h60007), "R6 R7 first byte from new target",
            {24'd0, byte_data}, {24'd0, bmod(20'h60007)});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule